// File: doc/BRIEF.md
# PCIe Root Port Power-Up Sequencer

This block brings a PCIe root port out of power-off in a fixed order and then waits for the link to come up. A start pulse launches the run. The sequencer holds the endpoint's fundamental reset and asks the PHY to initialise. It then turns on the supply regulators, the clocks and the core reset, asks the PHY to power on, and releases the fundamental reset. After a configuration step it enables link training and polls a link-active status input. Every interval between steps is counted on a one-microsecond tick input. The interval lengths are parameters, so a simulation can shorten them.

Each external step raises a level request and waits for a one-cycle pulse on a shared acknowledge or error input. An error on a step moves the sequencer into a reverse-order unwind path, entered at the point that matches the failed step. A regulator failure is the exception: it only sets a warning flag. The outcome is reported on a done flag and a two-bit status. Both hold until the next accepted start.

Top module: `pcie_rp_bringup`

## Requirements
- R1: After an accepted start, the requests come in this order: fundamental reset asserted, PHY init (phy_cmd 0), regulators on, clocks on, core reset asserted, core reset released, PHY power-on (phy_cmd 1), fundamental reset released, configuration (cfg_req), link training. Each handshaked request stays raised, with its phy_cmd unchanged, until ack_i or err_i pulses. Each request appears on the clock edge after the previous acknowledge.
- R2: The PHY init request rises exactly T_STEP_US ticks after the start is accepted. The regulator enables rise exactly T_STEP_US ticks after the PHY init acknowledge.
- R3: After its acknowledge, the core reset stays asserted for exactly T_STEP_US ticks and is then released. The PHY power-on request follows T_STEP_US ticks after the release acknowledge.
- R4: perst_o stays high for exactly T_PERST_US ticks after the PHY power-on acknowledge and then falls. cfg_req rises exactly T_STEP_US ticks later and is never raised while perst_o is high.
- R5: train_en rises only on the edge after the configuration acknowledge and is never high while perst_o is high.
- R6: An error pulse during the regulator step sets warn. The sequence still goes on to the clock enable.
- R7: link_active is checked on the cycle after train_en rises, and again every T_POLL_US ticks after each failed check, for at most POLL_TRIES checks. A check that sees link_active high ends the run with status 01. If all checks fail, the run ends with status 10, exactly (POLL_TRIES-1)*T_POLL_US ticks after train_en rose.
- R8: The status codes are 00 idle/busy, 01 link up, 10 timeout and 11 error. done is high exactly when the status is nonzero. done and status hold until the next accepted start, which returns both to zero.
- R9: On an error the unwind runs in this order: core reset reassert, clocks off, PHY power-off (phy_cmd 2), PHY exit (phy_cmd 3). It ends with status 11. The entry point depends on the failed step:
  - configuration error: enters at core reset reassert;
  - core reset assert error: enters at clocks off;
  - clock enable error or core reset release error: enters at PHY power-off;
  - PHY power-on error: enters at PHY exit;
  - PHY init error: ends at once, with no unwind request.
  An error on an unwind step is treated as an acknowledge.
- R10: A start pulse while a run is in progress is ignored. It changes neither the status nor any interval.
- R11: After reset, perst_o is high and every other output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| start | input | 1 | Starts a run when idle or finished |
| ack_i | input | 1 | Acknowledge pulse for the current step |
| err_i | input | 1 | Error pulse for the current step |
| link_active | input | 1 | Data-link-layer active status |
| perst_o | output | 1 | Fundamental reset to the endpoint, high = asserted |
| phy_req | output | 1 | PHY command request |
| phy_cmd | output | 2 | PHY command: 0 init, 1 power on, 2 power off, 3 exit |
| reg_en | output | N_SUPPLY | Regulator enables |
| clk_en | output | 1 | Clock enable request |
| core_rst | output | 1 | Core reset request |
| cfg_req | output | 1 | Configuration request |
| train_en | output | 1 | Link training enable |
| done | output | 1 | Run finished |
| status | output | 2 | Result code |
| warn | output | 1 | Regulator step reported an error |

## Verification
Each request becomes visible on the clock edge after the acknowledge that enables it, because all outputs are registered from the next state. The bench therefore drives each acknowledge for one cycle and samples every result on the following falling edge. Delays are measured in ticks rather than cycles. Ticks arrive every fourth cycle, so no tick coincides with the load edge or the exit edge of a delay. That makes the tick count between two sampled output changes equal the parameter exactly. For the timeout run, the result is due (POLL_TRIES-1)*T_POLL_US ticks after train_en rises, and the bench counts ticks over that window.

// File: rtl/rp_bringup_pkg.sv
package rp_bringup_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_PERST_DLY, S_PHY_INIT, S_INIT_DLY, S_REG_ON, S_CLK_ON,
    S_RST_SET, S_RST_DLY, S_RST_CLR, S_CLR_DLY, S_PHY_PWR, S_PERST_HOLD,
    S_REL_DLY, S_CFG, S_POLL, S_POLL_DLY, S_UP, S_TMO,
    S_U_RST, S_U_CLK, S_U_PHYOFF, S_U_PHYEXIT, S_ERR
  } rp_state_e;

  localparam logic [1:0] CMD_INIT = 2'd0;
  localparam logic [1:0] CMD_PWR  = 2'd1;
  localparam logic [1:0] CMD_OFF  = 2'd2;
  localparam logic [1:0] CMD_EXIT = 2'd3;

  localparam logic [1:0] RES_NONE = 2'b00;
  localparam logic [1:0] RES_UP   = 2'b01;
  localparam logic [1:0] RES_TMO  = 2'b10;
  localparam logic [1:0] RES_ERR  = 2'b11;

endpackage

// File: rtl/rp_delay_timer.sv
module rp_delay_timer #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (tick && (cnt_q != '0))
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/rp_try_counter.sv
module rp_try_counter #(
  parameter int TRIES = 10,
  parameter int W     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (inc)
      cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == W'(TRIES - 1));

  AST_TRY_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q < W'(TRIES)); // R7

endmodule

// File: rtl/pcie_rp_bringup.sv
module pcie_rp_bringup
  import rp_bringup_pkg::*;
#(
  parameter int T_STEP_US  = 1000,
  parameter int T_PERST_US = 100000,
  parameter int T_POLL_US  = 100000,
  parameter int POLL_TRIES = 10,
  parameter int N_SUPPLY   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_us,
  input  logic                start,
  input  logic                ack_i,
  input  logic                err_i,
  input  logic                link_active,
  output logic                perst_o,
  output logic                phy_req,
  output logic [1:0]          phy_cmd,
  output logic [N_SUPPLY-1:0] reg_en,
  output logic                clk_en,
  output logic                core_rst,
  output logic                cfg_req,
  output logic                train_en,
  output logic                done,
  output logic [1:0]          status,
  output logic                warn
);

  localparam int MAX_A = (T_STEP_US > T_PERST_US) ? T_STEP_US : T_PERST_US;
  localparam int MAX_D = (MAX_A > T_POLL_US) ? MAX_A : T_POLL_US;
  localparam int CNT_W = $clog2(MAX_D + 1);
  localparam int TRY_W = (POLL_TRIES > 1) ? $clog2(POLL_TRIES + 1) : 1;

  rp_state_e state_q, state_d;
  logic dly_load, dly_done, try_last, try_clr, try_inc, begin_run;
  logic [CNT_W-1:0] dly_val;

  function automatic logic is_delay(rp_state_e s);
    return (s == S_PERST_DLY) || (s == S_INIT_DLY) || (s == S_RST_DLY) ||
           (s == S_CLR_DLY) || (s == S_PERST_HOLD) || (s == S_REL_DLY) ||
           (s == S_POLL_DLY);
  endfunction

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE, S_UP, S_TMO, S_ERR: if (start) state_d = S_PERST_DLY;
      S_PERST_DLY:  if (dly_done) state_d = S_PHY_INIT;
      S_PHY_INIT:   if (err_i) state_d = S_ERR;
                    else if (ack_i) state_d = S_INIT_DLY;
      S_INIT_DLY:   if (dly_done) state_d = S_REG_ON;
      S_REG_ON:     if (err_i || ack_i) state_d = S_CLK_ON;
      S_CLK_ON:     if (err_i) state_d = S_U_PHYOFF;
                    else if (ack_i) state_d = S_RST_SET;
      S_RST_SET:    if (err_i) state_d = S_U_CLK;
                    else if (ack_i) state_d = S_RST_DLY;
      S_RST_DLY:    if (dly_done) state_d = S_RST_CLR;
      S_RST_CLR:    if (err_i) state_d = S_U_PHYOFF;
                    else if (ack_i) state_d = S_CLR_DLY;
      S_CLR_DLY:    if (dly_done) state_d = S_PHY_PWR;
      S_PHY_PWR:    if (err_i) state_d = S_U_PHYEXIT;
                    else if (ack_i) state_d = S_PERST_HOLD;
      S_PERST_HOLD: if (dly_done) state_d = S_REL_DLY;
      S_REL_DLY:    if (dly_done) state_d = S_CFG;
      S_CFG:        if (err_i) state_d = S_U_RST;
                    else if (ack_i) state_d = S_POLL;
      S_POLL:       if (link_active) state_d = S_UP;
                    else if (try_last) state_d = S_TMO;
                    else state_d = S_POLL_DLY;
      S_POLL_DLY:   if (dly_done) state_d = S_POLL;
      S_U_RST:      if (err_i || ack_i) state_d = S_U_CLK;
      S_U_CLK:      if (err_i || ack_i) state_d = S_U_PHYOFF;
      S_U_PHYOFF:   if (err_i || ack_i) state_d = S_U_PHYEXIT;
      S_U_PHYEXIT:  if (err_i || ack_i) state_d = S_ERR;
      default:      state_d = S_IDLE;
    endcase
  end

  assign dly_load  = is_delay(state_d) && (state_d != state_q);
  assign dly_val   = (state_d == S_PERST_HOLD) ? CNT_W'(T_PERST_US) :
                     (state_d == S_POLL_DLY)   ? CNT_W'(T_POLL_US)  :
                                                 CNT_W'(T_STEP_US);
  assign try_clr   = (state_q == S_CFG);
  assign try_inc   = (state_q == S_POLL) && (state_d == S_POLL_DLY);
  assign begin_run = (state_d == S_PERST_DLY) && (state_q != S_PERST_DLY);

  rp_delay_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(dly_load), .load_val(dly_val),
    .tick(tick_us), .expired(dly_done)
  );

  rp_try_counter #(.TRIES(POLL_TRIES), .W(TRY_W)) u_tries (
    .clk(clk), .rst(rst), .clr(try_clr), .inc(try_inc), .last(try_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      perst_o  <= 1'b1;
      reg_en   <= '0;
      clk_en   <= 1'b0;
      core_rst <= 1'b0;
      train_en <= 1'b0;
      warn     <= 1'b0;
      phy_req  <= 1'b0;
      phy_cmd  <= CMD_INIT;
      cfg_req  <= 1'b0;
      done     <= 1'b0;
      status   <= RES_NONE;
    end else begin
      state_q <= state_d;

      if (begin_run) perst_o <= 1'b1;
      else if (state_d == S_REL_DLY) perst_o <= 1'b0;

      if (begin_run) reg_en <= '0;
      else if (state_d == S_REG_ON) reg_en <= '1;

      if (begin_run || state_d == S_U_CLK) clk_en <= 1'b0;
      else if (state_d == S_CLK_ON) clk_en <= 1'b1;

      if (begin_run || state_d == S_RST_CLR) core_rst <= 1'b0;
      else if (state_d == S_RST_SET || state_d == S_U_RST) core_rst <= 1'b1;

      if (begin_run) train_en <= 1'b0;
      else if (state_d == S_POLL) train_en <= 1'b1;

      if (begin_run) warn <= 1'b0;
      else if (state_q == S_REG_ON && err_i) warn <= 1'b1;

      phy_req <= (state_d == S_PHY_INIT) || (state_d == S_PHY_PWR) ||
                 (state_d == S_U_PHYOFF) || (state_d == S_U_PHYEXIT);
      case (state_d)
        S_PHY_PWR:   phy_cmd <= CMD_PWR;
        S_U_PHYOFF:  phy_cmd <= CMD_OFF;
        S_U_PHYEXIT: phy_cmd <= CMD_EXIT;
        default:     phy_cmd <= CMD_INIT;
      endcase
      cfg_req <= (state_d == S_CFG);

      done <= (state_d == S_UP) || (state_d == S_TMO) || (state_d == S_ERR);
      case (state_d)
        S_UP:    status <= RES_UP;
        S_TMO:   status <= RES_TMO;
        S_ERR:   status <= RES_ERR;
        default: status <= RES_NONE;
      endcase
    end
  end

  AST_PWR_ORDER: assert property (@(posedge clk) disable iff (rst)
    (phy_req && phy_cmd == CMD_PWR) |-> (clk_en && !core_rst && (&reg_en))); // R1
  AST_PHY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phy_req && !ack_i && !err_i) |=> (phy_req && $stable(phy_cmd))); // R1
  AST_CFG_RELEASED: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> !perst_o); // R4
  AST_TRAIN_RELEASED: assert property (@(posedge clk) disable iff (rst)
    train_en |-> !perst_o); // R5
  AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (rst)
    !done |-> (status == RES_NONE)); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(status))); // R8

endmodule

// File: tb/pcie_rp_bringup_test.sv
module pcie_rp_bringup_test;

  localparam int TS = 6;
  localparam int TP = 25;
  localparam int TQ = 10;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 1'b0, start = 1'b0, ack_i = 1'b0, err_i = 1'b0, link_active = 1'b0;
  logic perst_o, phy_req, clk_en, core_rst, cfg_req, train_en, done, warn;
  logic [1:0] phy_cmd, reg_en, status;

  int n_cmp = 0, n_bad = 0, tk = 0, t_mark = 0, dt = 0;

  pcie_rp_bringup #(.T_STEP_US(TS), .T_PERST_US(TP), .T_POLL_US(TQ),
                    .POLL_TRIES(NT), .N_SUPPLY(2)) uut (
    .clk(clk), .rst(rst), .tick_us(tick_us), .start(start), .ack_i(ack_i),
    .err_i(err_i), .link_active(link_active), .perst_o(perst_o),
    .phy_req(phy_req), .phy_cmd(phy_cmd), .reg_en(reg_en), .clk_en(clk_en),
    .core_rst(core_rst), .cfg_req(cfg_req), .train_en(train_en),
    .done(done), .status(status), .warn(warn)
  );

  always #4 clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      tick_us = (c % 4 == 0);
    end
  end

  always @(posedge clk) if (!rst && tick_us) tk <= tk + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit cond(input int code);
    case (code)
      0:  return phy_req && phy_cmd == 2'd0;
      1:  return phy_req && phy_cmd == 2'd1;
      4:  return reg_en == 2'b11;
      5:  return clk_en;
      6:  return core_rst;
      7:  return !core_rst;
      8:  return cfg_req;
      9:  return !clk_en;
      10: return train_en;
      11: return done;
      12: return !perst_o;
      13: return phy_req;
      default: return 1'b0;
    endcase
  endfunction

  task automatic waitc(input int code, output int d);
    int n = 0;
    while (!cond(code) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) check(1'b0, "R1 wait", code, -1);
    d = tk - t_mark;
  endtask

  task automatic respond(input bit fail);
    if (fail) err_i = 1'b1; else ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    err_i = 1'b0;
    t_mark = tk;
  endtask

  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t_mark = tk;
  endtask

  task automatic run_front(input int fail_at);
    do_start();
    check(done == 1'b0 && status == 2'b00, "R8 cleared by start", status, 0);
    waitc(0, dt); respond(fail_at == 1); if (fail_at == 1) return;
    waitc(4, dt); respond(1'b0);
    waitc(5, dt); respond(fail_at == 2); if (fail_at == 2) return;
    waitc(6, dt); respond(fail_at == 3); if (fail_at == 3) return;
    waitc(7, dt); respond(fail_at == 4); if (fail_at == 4) return;
    waitc(1, dt); respond(fail_at == 5); if (fail_at == 5) return;
    waitc(8, dt); respond(fail_at == 6);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    repeat (150000) @(posedge clk);
    check(1'b0, "R1 watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(perst_o == 1'b1, "R11 perst_o", perst_o, 1);
    check({phy_req, reg_en, clk_en, core_rst, cfg_req, train_en, done, status, warn} == '0,
          "R11 outputs low", {phy_req, reg_en, clk_en, core_rst, cfg_req, train_en, done, status, warn}, 0);

    // Run 1: full sequence, regulator warning, link up at third check
    do_start();
    waitc(0, dt); check(dt == TS, "R2 start to PHY init", dt, TS);
    check(perst_o == 1'b1, "R1 perst held", perst_o, 1);
    respond(1'b0);
    waitc(4, dt); check(dt == TS, "R2 init to regulators", dt, TS);
    respond(1'b1);
    waitc(5, dt); check(warn == 1'b1, "R6 warn set", warn, 1);
    check(dt == 0, "R6 no extra delay", dt, 0);
    respond(1'b0);
    waitc(6, dt); respond(1'b0);
    waitc(7, dt); check(dt == TS, "R3 core reset hold", dt, TS);
    respond(1'b0);
    waitc(1, dt); check(dt == TS, "R3 release to PHY power", dt, TS);
    check(train_en == 1'b0, "R5 no training yet", train_en, 0);
    respond(1'b0);
    repeat (10) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitc(12, dt); check(dt == TP, "R4 perst hold", dt, TP);
    check(status == 2'b00 && done == 1'b0, "R10 start ignored", status, 0);
    t_mark = tk;
    waitc(8, dt); check(dt == TS, "R4 release to cfg", dt, TS);
    check(train_en == 1'b0, "R5 training waits for cfg", train_en, 0);
    respond(1'b0);
    check(train_en == 1'b1 && perst_o == 1'b0, "R5 training after cfg", train_en, 1);
    while (tk < t_mark + TQ + 2) @(negedge clk);
    link_active = 1'b1;
    waitc(11, dt);
    check(status == 2'b01, "R7 link up status", status, 1);
    check(dt == 2 * TQ, "R7 up after third check", dt, 2 * TQ);
    repeat (20) @(negedge clk);
    check(done == 1'b1 && status == 2'b01, "R8 result held", status, 1);
    check(warn == 1'b1, "R6 warn held", warn, 1);
    link_active = 1'b0;

    // Run 2: timeout
    run_front(0);
    check(warn == 1'b0, "R6 warn cleared", warn, 0);
    waitc(11, dt);
    check(status == 2'b10, "R7 timeout status", status, 2);
    check(dt == (NT - 1) * TQ, "R7 timeout window", dt, (NT - 1) * TQ);

    // Run 3: PHY init error
    run_front(1);
    check(done == 1'b1 && status == 2'b11, "R9 init error status", status, 3);
    check(phy_req == 1'b0, "R9 init error no unwind", phy_req, 0);

    // Run 4: PHY power-on error enters at PHY exit
    run_front(5);
    waitc(13, dt); check(phy_cmd == 2'd3, "R9 power error exit cmd", phy_cmd, 3);
    respond(1'b0);
    check(status == 2'b11, "R9 power error status", status, 3);

    // Run 5: clock error enters at PHY power-off
    run_front(2);
    waitc(13, dt); check(phy_cmd == 2'd2, "R9 clock error off cmd", phy_cmd, 2);
    respond(1'b0);
    waitc(13, dt); check(phy_cmd == 2'd3, "R9 clock error exit cmd", phy_cmd, 3);
    respond(1'b0);
    check(status == 2'b11, "R9 clock error status", status, 3);

    // Run 6: core reset assert error enters at clocks off; unwind error acts as ack
    run_front(3);
    waitc(9, dt); check(phy_req == 1'b0, "R9 clocks off first", phy_req, 0);
    respond(1'b1);
    waitc(13, dt); check(phy_cmd == 2'd2, "R9 reset error off cmd", phy_cmd, 2);
    respond(1'b0);
    waitc(13, dt); respond(1'b0);
    check(status == 2'b11, "R9 reset error status", status, 3);

    // Run 7: configuration error enters at core reset reassert
    run_front(6);
    check(core_rst == 1'b1 && clk_en == 1'b1, "R9 core reset reassert", core_rst, 1);
    respond(1'b0);
    check(clk_en == 1'b0 && phy_req == 1'b0, "R9 clocks off", clk_en, 0);
    respond(1'b0);
    check(phy_req && phy_cmd == 2'd2, "R9 cfg error off cmd", phy_cmd, 2);
    respond(1'b0);
    check(phy_req && phy_cmd == 2'd3, "R9 cfg error exit cmd", phy_cmd, 3);
    respond(1'b0);
    check(done == 1'b1 && status == 2'b11, "R9 cfg error status", status, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule